// File: doc/BRIEF.md
# Byte-Serial State Save/Restore Port

This block gives software a way to capture and reload 32-bit internal state words through an 8-bit CPU port. Software first writes an index that picks a target, then makes repeated accesses to a data port. Each access moves one byte, least significant first. An internal byte position counter steps after every access to a state word. Any index write sets that counter back to the first byte. Reads and writes share the same counter, so a save sequence and a restore sequence have the same shape.

There are two state words. One holds a video data latch and the other holds a palette-interface state word. Both are modelled as plain registers. The logic that owns them can load a whole word in one cycle and can observe each word at all times. A third, read-only index reports a 5-bit blink counter that comes from another clock domain. That value passes through a two-flop synchronizer before it can be read. All bus strobes are single-cycle. Read data is registered.

Top module: `savres_port`

## Requirements
- R1: After reset the index register, the byte counter, the read data register and both state words are all zero.
- R2: An index write loads the index and clears the byte counter to byte 0. A data strobe in the same cycle as an index write is ignored.
- R3: At a state-word index, successive data accesses address byte 0 (bits 7:0), then byte 1 (bits 15:8), then byte 2 (bits 23:16), then byte 3 (bits 31:24). The fifth access wraps back to byte 0.
- R4: Data reads and data writes advance the one shared byte counter, in any mix.
- R5: Index 0x70 selects the data-latch word (`latch_q`) and index 0x71 selects the palette word (`pal_q`). A data write changes only the addressed byte of the selected word, and the new byte appears on the word output on the next clock.
- R6: `dat_rdata` updates on the clock edge that follows an accepted read strobe, and it holds its value in every other cycle.
- R7: A read at index 0x61 returns zeros in bits 7:5 and the synchronized `blink_async` value in bits 4:0. That value is sampled through two flops.
- R8: A write to index 0x61, and any access at an index other than 0x61, 0x70 or 0x71, changes neither state word nor the byte counter. A read at such an unmapped index returns 0x00.
- R9: An owner load (`latch_ld` or `pal_ld`) replaces the whole word on the next clock. It wins over a CPU byte write to the same word in the same cycle, but that CPU write still advances the counter.
- R10: If `dat_we` and `dat_re` are both asserted, only the write takes effect. The read data register holds its value, and the counter advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| idx_we | input | 1 | Index write strobe |
| idx_wdata | input | 8 | Index value |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 8 | Data write byte |
| dat_re | input | 1 | Data read strobe |
| dat_rdata | output | 8 | Registered read byte |
| latch_ld | input | 1 | Owner load strobe for the data-latch word |
| latch_ld_val | input | 32 | Owner load value for the data-latch word |
| latch_q | output | 32 | Current data-latch word |
| pal_ld | input | 1 | Owner load strobe for the palette word |
| pal_ld_val | input | 32 | Owner load value for the palette word |
| pal_q | output | 32 | Current palette word |
| blink_async | input | 5 | Blink counter from the other clock domain |

## Verification
The bench builds the block with its default parameters: four bytes per word, a 5-bit blink field, two synchronizer stages, and indices 0x70, 0x71 and 0x61. With four bytes per word, a wrap is reached after just five accesses. Mixed read/write sequences can therefore cross the counter wrap and reach a counter cleared in mid-sequence, both within a few cycles. The 5-bit blink width leaves three upper bits that must read as zero, and a short idle period covers the two-stage synchronizer latency. Collisions are driven on purpose:
- index write with data write;
- owner load with CPU write;
- read strobe with write strobe.

// File: rtl/savres_pkg.sv
package savres_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_PAL   = 2'd2,
    SEL_BLINK = 2'd3
  } sel_e;
endpackage

// File: rtl/savres_rst_sync.sv
module savres_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/savres_sync.sv
module savres_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/savres_word.sv
module savres_word
  import savres_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned CNT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    ld_i,
  input  logic [BYTES*BYTE_W-1:0] ld_val_i,
  input  logic                    wr_i,
  input  logic [CNT_W-1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0]       wr_byte_i,
  output logic [BYTES*BYTE_W-1:0] q_o
);
  logic [BYTE_W-1:0] byte_q [BYTES];
  logic [BYTE_W-1:0] byte_d [BYTES];
  logic [BYTES-1:0]  byte_en;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    // owner load has priority over a CPU byte write
    always_comb begin
      byte_en[b] = ld_i | (wr_i & (wr_sel_i == CNT_W'(b)));
      byte_d[b]  = ld_i ? ld_val_i[b*BYTE_W +: BYTE_W] : wr_byte_i;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)         byte_q[b] <= '0;
      else if (byte_en[b]) byte_q[b] <= byte_d[b];
    end

    assign q_o[b*BYTE_W +: BYTE_W] = byte_q[b];
  end
endmodule

// File: rtl/savres_port.sv
module savres_port
  import savres_pkg::*;
#(
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned BLINK_W     = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  IDX_LATCH   = 8'h70,
  parameter logic [7:0]  IDX_PAL     = 8'h71,
  parameter logic [7:0]  IDX_BLINK   = 8'h61
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         idx_we,
  input  logic [7:0]                   idx_wdata,
  input  logic                         dat_we,
  input  logic [7:0]                   dat_wdata,
  input  logic                         dat_re,
  output logic [7:0]                   dat_rdata,
  input  logic                         latch_ld,
  input  logic [WORD_BYTES*BYTE_W-1:0] latch_ld_val,
  output logic [WORD_BYTES*BYTE_W-1:0] latch_q,
  input  logic                         pal_ld,
  input  logic [WORD_BYTES*BYTE_W-1:0] pal_ld_val,
  output logic [WORD_BYTES*BYTE_W-1:0] pal_q,
  input  logic [BLINK_W-1:0]           blink_async
);
  localparam int unsigned CNT_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BYTES - 1);

  logic               rst_sync_n;
  logic [BLINK_W-1:0] blink_s;
  logic [7:0]         idx_q, idx_d;
  logic               idx_en;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cnt_en;
  logic [7:0]         rd_q, rd_d;
  logic               rd_en;
  sel_e               sel;
  logic               acc_wr, acc_rd, save_hit;
  logic [BYTE_W-1:0]  latch_byte [WORD_BYTES];
  logic [BYTE_W-1:0]  pal_byte   [WORD_BYTES];

  savres_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_no (rst_sync_n)
  );

  savres_sync #(.W(BLINK_W), .STAGES(SYNC_STAGES)) u_blink (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .d_i    (blink_async),
    .q_o    (blink_s)
  );

  // target decode
  always_comb begin
    if      (idx_q == IDX_LATCH) sel = SEL_LATCH;
    else if (idx_q == IDX_PAL)   sel = SEL_PAL;
    else if (idx_q == IDX_BLINK) sel = SEL_BLINK;
    else                         sel = SEL_NONE;
  end

  // strobe priority: index > write > read
  assign acc_wr   = dat_we & ~idx_we;
  assign acc_rd   = dat_re & ~idx_we & ~dat_we;
  assign save_hit = (sel == SEL_LATCH) | (sel == SEL_PAL);

  savres_word #(.BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_latch (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .ld_i      (latch_ld),
    .ld_val_i  (latch_ld_val),
    .wr_i      (acc_wr & (sel == SEL_LATCH)),
    .wr_sel_i  (cnt_q),
    .wr_byte_i (dat_wdata),
    .q_o       (latch_q)
  );

  savres_word #(.BYTES(WORD_BYTES), .CNT_W(CNT_W)) u_pal (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .ld_i      (pal_ld),
    .ld_val_i  (pal_ld_val),
    .wr_i      (acc_wr & (sel == SEL_PAL)),
    .wr_sel_i  (cnt_q),
    .wr_byte_i (dat_wdata),
    .q_o       (pal_q)
  );

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_split
    assign latch_byte[b] = latch_q[b*BYTE_W +: BYTE_W];
    assign pal_byte[b]   = pal_q[b*BYTE_W +: BYTE_W];
  end

  // next state
  always_comb begin
    idx_en = idx_we;
    idx_d  = idx_wdata;

    cnt_en = idx_we | (save_hit & (acc_wr | acc_rd));
    if (idx_we)                cnt_d = '0;
    else if (cnt_q == CNT_LAST) cnt_d = '0;
    else                        cnt_d = cnt_q + 1'b1;

    rd_en = acc_rd;
    unique case (sel)
      SEL_LATCH: rd_d = latch_byte[cnt_q];
      SEL_PAL:   rd_d = pal_byte[cnt_q];
      SEL_BLINK: rd_d = {{(8 - BLINK_W){1'b0}}, blink_s};
      default:   rd_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign dat_rdata = rd_q;
endmodule

// File: rtl/savres_chk.sv
module savres_chk #(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned BLINK_W    = 5,
  parameter int unsigned CNT_W      = 2,
  parameter logic [7:0]  IDX_LATCH  = 8'h70,
  parameter logic [7:0]  IDX_PAL    = 8'h71,
  parameter logic [7:0]  IDX_BLINK  = 8'h61
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic                    idx_we,
  input logic                    dat_we,
  input logic                    dat_re,
  input logic [7:0]              dat_rdata,
  input logic [7:0]              idx_q,
  input logic [CNT_W-1:0]        cnt_q,
  input logic                    latch_ld,
  input logic [WORD_BYTES*8-1:0] latch_ld_val,
  input logic [WORD_BYTES*8-1:0] latch_q,
  input logic                    pal_ld,
  input logic [WORD_BYTES*8-1:0] pal_q
);
  logic at_save, at_blink, at_none, any_acc;
  logic [CNT_W-1:0] cnt_next;

  assign at_save  = (idx_q == IDX_LATCH) || (idx_q == IDX_PAL);
  assign at_blink = (idx_q == IDX_BLINK);
  assign at_none  = !at_save && !at_blink;
  assign any_acc  = !idx_we && (dat_we || dat_re);
  assign cnt_next = (32'(cnt_q) == WORD_BYTES - 1) ? '0 : cnt_q + 1'b1;

  a_r2_idx_clears_cnt: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_we |=> (cnt_q == '0));

  a_r3_cnt_steps: assert property (@(posedge clk) disable iff (!rst_ni)
    (any_acc && at_save) |=> (cnt_q == $past(cnt_next)));

  a_r8_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_ni)
    (any_acc && !at_save && !latch_ld && !pal_ld)
      |=> ($stable(cnt_q) && $stable(latch_q) && $stable(pal_q)));

  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_re && !dat_we && !idx_we && at_none) |=> (dat_rdata == 8'h00));

  a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !(dat_re && !dat_we && !idx_we) |=> $stable(dat_rdata));

  a_r7_blink_upper_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (dat_re && !dat_we && !idx_we && at_blink) |=> (dat_rdata[7:BLINK_W] == '0));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    latch_ld |=> (latch_q == $past(latch_ld_val)));
endmodule

bind savres_port savres_chk #(
  .WORD_BYTES (WORD_BYTES),
  .BLINK_W    (BLINK_W),
  .CNT_W      (CNT_W),
  .IDX_LATCH  (IDX_LATCH),
  .IDX_PAL    (IDX_PAL),
  .IDX_BLINK  (IDX_BLINK)
) u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .idx_we       (idx_we),
  .dat_we       (dat_we),
  .dat_re       (dat_re),
  .dat_rdata    (dat_rdata),
  .idx_q        (idx_q),
  .cnt_q        (cnt_q),
  .latch_ld     (latch_ld),
  .latch_ld_val (latch_ld_val),
  .latch_q      (latch_q),
  .pal_ld       (pal_ld),
  .pal_q        (pal_q)
);

// File: tb/tb_savres_port.sv
module tb_savres_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic        dat_re = 1'b0;
  logic [7:0]  dat_rdata;
  logic        latch_ld = 1'b0;
  logic [31:0] latch_ld_val = '0;
  logic [31:0] latch_q;
  logic        pal_ld = 1'b0;
  logic [31:0] pal_ld_val = '0;
  logic [31:0] pal_q;
  logic [4:0]  blink_async = '0;

  int n_chk  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  savres_port dut (
    .clk, .rst_n, .idx_we, .idx_wdata, .dat_we, .dat_wdata, .dat_re,
    .dat_rdata, .latch_ld, .latch_ld_val, .latch_q, .pal_ld, .pal_ld_val,
    .pal_q, .blink_async
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each accepted read one edge later
  always @(posedge clk) rd_seen <= dat_re && !dat_we && !idx_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6: unexpected read result actual %h expected none", dat_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {24'h0, dat_rdata}, {24'h0, e.val});
      end
    end
  end

  // driver tasks: entered at a falling edge, leave at the next one
  task automatic idx_wr(input logic [7:0] v);
    idx_we = 1'b1; idx_wdata = v;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic dwr(input logic [7:0] v);
    dat_we = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic drd(input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    last_rd = exp;
    dat_re = 1'b1;
    @(negedge clk);
    dat_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R6: %0d reads never returned, actual 0 expected %0d", exp_q.size(), exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rdata", {24'h0, dat_rdata}, 32'h0);
    chk("R1 latch", latch_q, 32'h0);
    chk("R1 pal", pal_q, 32'h0);
    drd(8'h00, "R1 R8 read at reset index");

    // R5 byte writes into latch word
    idx_wr(8'h70);
    dwr(8'h11);
    chk("R5 first byte only", latch_q, 32'h0000_0011);
    dwr(8'h22); dwr(8'h33); dwr(8'h44);
    chk("R3 R5 latch word", latch_q, 32'h4433_2211);
    chk("R5 pal untouched", pal_q, 32'h0);

    // R3 read back with wrap
    idx_wr(8'h70);
    drd(8'h11, "R3 byte0"); drd(8'h22, "R3 byte1");
    drd(8'h33, "R3 byte2"); drd(8'h44, "R3 byte3");
    drd(8'h11, "R3 wrap");

    // R4 mixed reads and writes share the counter
    idx_wr(8'h70);
    drd(8'h11, "R4 read b0");
    dwr(8'hAA);
    drd(8'h33, "R4 read b2");
    dwr(8'hBB);
    chk("R4 latch mixed", latch_q, 32'hBB33_AA11);
    drd(8'h11, "R4 wrap");

    // R5 palette word
    idx_wr(8'h71);
    dwr(8'h01); dwr(8'h02); dwr(8'h03); dwr(8'h04);
    chk("R5 pal word", pal_q, 32'h0403_0201);
    chk("R5 latch kept", latch_q, 32'hBB33_AA11);

    // R2 index write mid-sequence clears counter
    idx_wr(8'h71);
    drd(8'h01, "R2 b0"); drd(8'h02, "R2 b1");
    idx_wr(8'h71);
    drd(8'h01, "R2 cleared");

    // R2 index write beats data write in same cycle
    idx_we = 1'b1; idx_wdata = 8'h71; dat_we = 1'b1; dat_wdata = 8'h99;
    @(negedge clk);
    idx_we = 1'b0; dat_we = 1'b0;
    chk("R2 data ignored", pal_q, 32'h0403_0201);
    drd(8'h01, "R2 counter zero");

    // R7 blink readback
    blink_async = 5'h15;
    idle(4);
    idx_wr(8'h61);
    drd(8'h15, "R7 blink");
    dwr(8'hFF);
    drd(8'h15, "R7 R8 blink after write");
    chk("R8 latch after ro write", latch_q, 32'hBB33_AA11);
    blink_async = 5'h1F;
    idle(4);
    drd(8'h1F, "R7 blink max");

    // R8 unmapped index
    idx_wr(8'h72);
    dwr(8'h55);
    drd(8'h00, "R8 unmapped read");
    chk("R8 latch", latch_q, 32'hBB33_AA11);
    chk("R8 pal", pal_q, 32'h0403_0201);

    // R10 write and read together
    idx_wr(8'h71);
    dat_we = 1'b1; dat_wdata = 8'hEE; dat_re = 1'b1;
    @(negedge clk);
    dat_we = 1'b0; dat_re = 1'b0;
    chk("R10 rdata held", {24'h0, dat_rdata}, {24'h0, last_rd});
    chk("R10 write done", pal_q, 32'h0403_02EE);
    drd(8'h02, "R10 single advance");

    // R9 owner load beats CPU write
    idx_wr(8'h70);
    latch_ld = 1'b1; latch_ld_val = 32'hDEAD_BEEF; dat_we = 1'b1; dat_wdata = 8'h77;
    @(negedge clk);
    latch_ld = 1'b0; dat_we = 1'b0;
    chk("R9 latch load wins", latch_q, 32'hDEAD_BEEF);
    drd(8'hBE, "R9 counter advanced");
    pal_ld = 1'b1; pal_ld_val = 32'h1234_5678;
    @(negedge clk);
    pal_ld = 1'b0;
    chk("R9 pal load", pal_q, 32'h1234_5678);

    // R6 hold while idle
    idle(3);
    chk("R6 hold", {24'h0, dat_rdata}, 32'h0000_00BE);

    idle(2);
    done = 1'b1;
    finish_run();
  end
endmodule